// File: doc/BRIEF.md
# Receive Filter Calibration Scheduler

This block decides when the receive-path filter tuning and the receive-path offset correction run. It starts a tuning run as soon as reset is released. It then repeats the tuning on a fixed background period, measured from the end of the previous run. Software controls it through a small configuration word. One bit turns the background schedule off and on again. A self-clearing bit asks for an offset correction. A read-only bit shows that a tuning run is in progress.

The scheduler does not tune anything itself. It sends a one-cycle start strobe to an external calibration engine and then waits. A run ends on the engine's done input or when an internal duration timer runs out, whichever comes first. Tuning and offset correction share the engine, so they never run together. A request that arrives while the other operation is running waits until that operation ends; it is never dropped. All periods and durations are parameters counted in clock cycles.

The controller has three states. `CAL_IDLE` is the wait state. `CAL_TUNE` drives a filter tuning run. `CAL_OFFSET` drives an offset correction. The transitions are:

- *idle-to-tune*: a tune is pending, or the background period has expired while the schedule is on.
- *idle-to-offset*: no tune is waiting and an offset request is pending.
- *tune-to-idle*: the engine reports done, or the tuning duration has expired.
- *offset-to-idle*: the engine reports done, or the offset duration has expired.

A state that is leaving always spends at least one cycle in `CAL_IDLE`.

Top module: `rxcal_sched`

## Requirements
- R1: While reset is held, the read word is 0 and both start strobes are 0. At the first clock edge after reset is released, a tuning run begins: `tune_start` is 1 for that one cycle and the busy bit (read bit 2) reads 1.
- R2: The busy bit reads 1 for every cycle of a tuning run. A run ends at the edge where `tune_done` is sampled high during it, or after `TUNE_CYC` cycles, whichever comes first. Busy then reads 0 for at least one cycle.
- R3: With the background schedule on and no other request, busy reads 0 for exactly `PERIOD_CYC`+1 cycles between the end of one run and the start of the next. The period count restarts at every run completion.
- R4: The write word has two bits: bit 0 is the background-off bit and bit 1 is the offset request. The busy bit lies outside the write word. No write can set or clear it, and a write during a tuning run does not shorten that run.
- R5: Writing bit 0 = 1 sets the background-off bit, which reads back on bit 0. While the bit stays 1, no periodic tuning run starts.
- R6: Writing bit 0 = 0 while the background-off bit is 1 clears it and requests a tuning run. If the block is idle, `tune_start` pulses two cycles after the write cycle. The periodic schedule then resumes.
- R7: Writing bit 1 = 1 sets read bit 1 from the next cycle on. The bit stays 1 until the offset correction finishes and then reads 0. `ofs_start` pulses once. Writing bit 1 = 1 while a correction is pending or running has no effect.
- R8: An offset correction ends at the edge where `ofs_done` is sampled high during it, or after `OFS_CYC` cycles, whichever comes first.
- R9: Tuning and offset correction never overlap. If both are pending in idle, tuning goes first. An offset request made during a tuning run starts after that run. A periodic run that falls due during a correction starts right after the correction ends.
- R10: Each start strobe is high for exactly one cycle, in the first cycle of its operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 2 | Write data: bit 0 background-off, bit 1 offset request |
| cfg_rdata | output | 3 | Read data: bit 0 background-off, bit 1 offset pending/running, bit 2 tuning busy |
| tune_start | output | 1 | One-cycle start strobe to the filter tuning engine |
| tune_done | input | 1 | Tuning engine completion |
| ofs_start | output | 1 | One-cycle start strobe to the offset correction engine |
| ofs_done | input | 1 | Offset engine completion |

## Verification
The assertions assume that the done inputs matter only in the state they belong to. A stray `tune_done` or `ofs_done` outside that state must have no effect. The assertions also assume that the engine may answer in any cycle, including the cycle of its start strobe. The stimulus keeps to these assumptions by raising the done inputs at random, regardless of state, and by writing random two-bit words at random times. A cycle model computes the expected strobes and read word for every cycle. Directed cases add timeout-only runs, done in the first cycles of a run, writes during a run, and an offset request timed so that a periodic run falls due while the correction is running.

// File: rtl/rxcal_pkg.sv
package rxcal_pkg;

    typedef enum logic [1:0] {
        CAL_IDLE   = 2'd0,
        CAL_TUNE   = 2'd1,
        CAL_OFFSET = 2'd2
    } cal_state_e;

    localparam int WR_W       = 2;
    localparam int RD_W       = 3;
    localparam int FLD_BG_OFF = 0;
    localparam int FLD_OFS_GO = 1;
    localparam int FLD_BUSY   = 2;

endpackage

// File: rtl/rxcal_period_timer.sv
module rxcal_period_timer #(
    parameter int PERIOD_CYC = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic hold,
    output logic due
);
    localparam int CW = $clog2(PERIOD_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(PERIOD_CYC);

    logic [CW-1:0] cnt_q;

    // Saturating count: it stays at the limit until the next clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (!hold && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign due = (cnt_q == LIM);

endmodule

// File: rtl/rxcal_dur_timer.sv
module rxcal_dur_timer #(
    parameter int TUNE_CYC = 62_500_000,
    parameter int OFS_CYC  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_ofs,
    output logic expire
);
    localparam int MAXC = (TUNE_CYC > OFS_CYC) ? TUNE_CYC : OFS_CYC;
    localparam int DW   = $clog2(MAXC + 1);
    localparam logic [DW-1:0] TUNE_LIM = DW'(TUNE_CYC - 1);
    localparam logic [DW-1:0] OFS_LIM  = DW'(OFS_CYC - 1);

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign limit  = sel_ofs ? OFS_LIM : TUNE_LIM;
    assign expire = run && (cnt_q == limit);

endmodule

// File: rtl/rxcal_cfg_regs.sv
module rxcal_cfg_regs
    import rxcal_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [WR_W-1:0] wdata,
    input  logic            tune_grant,
    input  logic            ofs_grant,
    input  logic            ofs_active,
    output logic            bg_off,
    output logic            tune_pend,
    output logic            ofs_pend
);
    logic tune_req_wr;
    logic ofs_req_wr;

    // Re-enabling the schedule is what asks for an immediate tuning run.
    assign tune_req_wr = we && !wdata[FLD_BG_OFF] && bg_off;
    assign ofs_req_wr  = we && wdata[FLD_OFS_GO] && !ofs_pend && !ofs_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bg_off <= 1'b0;
        end else if (we) begin
            bg_off <= wdata[FLD_BG_OFF];
        end
    end

    // Reset value 1: the first tuning run follows reset release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tune_pend <= 1'b1;
        end else if (tune_req_wr) begin
            tune_pend <= 1'b1;
        end else if (tune_grant) begin
            tune_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_pend <= 1'b0;
        end else if (ofs_grant) begin
            ofs_pend <= 1'b0;
        end else if (ofs_req_wr) begin
            ofs_pend <= 1'b1;
        end
    end

endmodule

// File: rtl/rxcal_sched.sv
module rxcal_sched
    import rxcal_pkg::*;
#(
    parameter int PERIOD_CYC = 250_000_000,
    parameter int TUNE_CYC   = 62_500_000,
    parameter int OFS_CYC    = 4096
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [WR_W-1:0] cfg_wdata,
    output logic [RD_W-1:0] cfg_rdata,
    output logic            tune_start,
    input  logic            tune_done,
    output logic            ofs_start,
    input  logic            ofs_done
);
    cal_state_e state_q, state_d;

    logic bg_off, tune_pend, ofs_pend;
    logic due, due_ok, expire;
    logic tune_end, ofs_end;
    logic tune_grant, ofs_grant;
    logic tune_start_q, ofs_start_q;

    rxcal_cfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .wdata      (cfg_wdata),
        .tune_grant (tune_grant),
        .ofs_grant  (ofs_grant),
        .ofs_active (state_q == CAL_OFFSET),
        .bg_off     (bg_off),
        .tune_pend  (tune_pend),
        .ofs_pend   (ofs_pend)
    );

    rxcal_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_period (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tune_end || bg_off),
        .hold  (state_q == CAL_TUNE),
        .due   (due)
    );

    rxcal_dur_timer #(.TUNE_CYC(TUNE_CYC), .OFS_CYC(OFS_CYC)) u_dur (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q != CAL_IDLE),
        .sel_ofs (state_q == CAL_OFFSET),
        .expire  (expire)
    );

    assign due_ok   = due && !bg_off;
    assign tune_end = (state_q == CAL_TUNE)   && (tune_done || expire);
    assign ofs_end  = (state_q == CAL_OFFSET) && (ofs_done  || expire);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_IDLE: begin
                if (tune_pend || due_ok) begin
                    state_d = CAL_TUNE;
                end else if (ofs_pend) begin
                    state_d = CAL_OFFSET;
                end
            end
            CAL_TUNE: begin
                if (tune_end) begin
                    state_d = CAL_IDLE;
                end
            end
            CAL_OFFSET: begin
                if (ofs_end) begin
                    state_d = CAL_IDLE;
                end
            end
            default: state_d = CAL_IDLE;
        endcase
    end

    assign tune_grant = (state_q == CAL_IDLE) && (state_d == CAL_TUNE);
    assign ofs_grant  = (state_q == CAL_IDLE) && (state_d == CAL_OFFSET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tune_start_q <= 1'b0;
            ofs_start_q  <= 1'b0;
        end else begin
            tune_start_q <= tune_grant;
            ofs_start_q  <= ofs_grant;
        end
    end

    assign tune_start              = tune_start_q;
    assign ofs_start               = ofs_start_q;
    assign cfg_rdata[FLD_BG_OFF]   = bg_off;
    assign cfg_rdata[FLD_OFS_GO]   = ofs_pend || (state_q == CAL_OFFSET);
    assign cfg_rdata[FLD_BUSY]     = (state_q == CAL_TUNE);

endmodule

// File: rtl/rxcal_sched_chk.sv
module rxcal_sched_chk #(
    parameter int TUNE_CYC = 62_500_000,
    parameter int OFS_CYC  = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cfg_rdata,
    input logic       tune_start,
    input logic       tune_done,
    input logic       ofs_start,
    input logic       ofs_done
);
    int   tune_run;
    int   ofs_run;
    logic ofs_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tune_run <= 0;
        end else if (cfg_rdata[2]) begin
            tune_run <= tune_run + 1;
        end else begin
            tune_run <= 0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_run <= 0;
            ofs_act <= 1'b0;
        end else if (ofs_start) begin
            ofs_run <= 1;
            ofs_act <= 1'b1;
        end else if (ofs_act && cfg_rdata[1]) begin
            ofs_run <= ofs_run + 1;
        end else begin
            ofs_act <= 1'b0;
        end
    end

    assert_tune_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tune_start |=> !tune_start) else $error("tune_start wider than one cycle");

    assert_ofs_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_start |=> !ofs_start) else $error("ofs_start wider than one cycle");

    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tune_start |-> cfg_rdata[2]) else $error("tune_start without busy");

    assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2] && tune_done) |=> !cfg_rdata[2]) else $error("tune run outlived done");

    assert_tune_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[2] |-> (tune_run < TUNE_CYC)) else $error("tune run too long");

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_start |-> (!cfg_rdata[2] && cfg_rdata[1])) else $error("offset overlaps tune");

    assert_ofs_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_act && cfg_rdata[1]) |-> (ofs_run < OFS_CYC)) else $error("offset too long");

    assert_ofs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ofs_start || (ofs_act && cfg_rdata[1])) && ofs_done) |=> !cfg_rdata[1])
        else $error("offset outlived done");

endmodule

bind rxcal_sched rxcal_sched_chk #(.TUNE_CYC(TUNE_CYC), .OFS_CYC(OFS_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rdata  (cfg_rdata),
    .tune_start (tune_start),
    .tune_done  (tune_done),
    .ofs_start  (ofs_start),
    .ofs_done   (ofs_done)
);

// File: tb/test_rxcal_sched.sv
module test_rxcal_sched;
    localparam int P = 40;
    localparam int T = 12;
    localparam int O = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic [2:0] cfg_rdata;
    logic       tune_start, ofs_start;
    logic       tune_done = 1'b0;
    logic       ofs_done = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    rxcal_sched #(.PERIOD_CYC(P), .TUNE_CYC(T), .OFS_CYC(O)) i_rxcal_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tune_start(tune_start), .tune_done(tune_done),
        .ofs_start(ofs_start), .ofs_done(ofs_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] d);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Cycle model built from the requirements (states 0 idle, 1 tune, 2 offset)
    int m_st, m_dur, m_per;
    bit m_tp, m_op, m_dis, m_ts, m_os;

    function automatic int next_state(int st, bit et, bit eo, bit tp, bit due, bit op);
        if (st == 0) return (tp || due) ? 1 : (op ? 2 : 0);
        if (st == 1) return et ? 0 : 1;
        return eo ? 0 : 2;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_dur = 0; m_per = 0;
            m_tp = 1; m_op = 0; m_dis = 0; m_ts = 0; m_os = 0;
        end else begin
            bit et, eo, due, gt, go;
            int nst, nper, ndur;
            bit ntp, nop, ndis;
            et   = (m_st == 1) && (tune_done || m_dur == T - 1);
            eo   = (m_st == 2) && (ofs_done || m_dur == O - 1);
            due  = (m_per == P) && !m_dis;
            nst  = next_state(m_st, et, eo, m_tp, due, m_op);
            gt   = (m_st == 0) && (nst == 1);
            go   = (m_st == 0) && (nst == 2);
            nper = et ? 0 : (m_dis ? 0 : ((m_st == 1) ? m_per : ((m_per != P) ? m_per + 1 : m_per)));
            ndur = (m_st != 0) ? m_dur + 1 : 0;
            ntp  = (cfg_we && !cfg_wdata[0] && m_dis) ? 1'b1 : (gt ? 1'b0 : m_tp);
            nop  = go ? 1'b0 : ((cfg_we && cfg_wdata[1] && !m_op && m_st != 2) ? 1'b1 : m_op);
            ndis = cfg_we ? cfg_wdata[0] : m_dis;
            m_ts = gt; m_os = go;
            m_st = nst; m_per = nper; m_dur = ndur;
            m_tp = ntp; m_op = nop; m_dis = ndis;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R10 tune_start vs model", tune_start, m_ts);
            check("R10 ofs_start vs model", ofs_start, m_os);
            check("R2 busy bit vs model", cfg_rdata[2], m_st == 1);
            check("R7 offset bit vs model", cfg_rdata[1], m_op || m_st == 2);
            check("R5 background-off bit vs model", cfg_rdata[0], m_dis);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000 && !done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<60000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        int c, g, oc, n;
        process::self().srandom(32'h5EED_0042);
        cyc(3);
        // R1 reset state
        check("R1 reset read word", cfg_rdata, 0);
        check("R1 reset tune_start", tune_start, 0);
        rst_n = 1'b1;
        cyc(1);
        check("R1 tune_start after release", tune_start, 1);
        check("R1 busy after release", cfg_rdata[2], 1);
        // R2 full-length run without done
        c = 0;
        while (cfg_rdata[2]) begin c++; cyc(1); end
        check("R2 run length on timeout", c, T);
        // R3 background gap
        g = 0;
        while (!cfg_rdata[2]) begin g++; cyc(1); end
        check("R3 idle gap between runs", g, P + 1);
        check("R3 periodic tune_start", tune_start, 1);
        // R2 done ends the run
        cyc(2);
        tune_done = 1'b1;
        cyc(1);
        tune_done = 1'b0;
        check("R2 busy after done", cfg_rdata[2], 0);
        // R5 background off
        wr(2'b01);
        n = 0;
        for (int i = 0; i < 3 * P; i++) begin n += tune_start; cyc(1); end
        check("R5 no periodic run while off", n, 0);
        check("R5 off bit reads 1", cfg_rdata[0], 1);
        // R6 re-enable fires a run
        wr(2'b00);
        check("R6 no strobe yet", tune_start, 0);
        cyc(1);
        check("R6 tune_start two cycles after write", tune_start, 1);
        check("R6 off bit cleared", cfg_rdata[0], 0);
        // R4 write during a run does not shorten it
        cyc(1);
        wr(2'b01);
        c = 2;
        while (cfg_rdata[2]) begin c++; cyc(1); end
        check("R4 run length with write inside", c, T);
        // R7 offset request, R8 timeout
        wr(2'b11);
        check("R7 offset bit set", cfg_rdata[1], 1);
        check("R7 no strobe yet", ofs_start, 0);
        cyc(1);
        check("R7 ofs_start", ofs_start, 1);
        wr(2'b11);
        oc = 1;
        while (cfg_rdata[1]) begin oc++; cyc(1); end
        check("R8 offset length on timeout", oc, O);
        n = 0;
        for (int i = 0; i < 10; i++) begin n += ofs_start; cyc(1); end
        check("R7 repeated request ignored", n, 0);
        // R8 done ends the correction
        wr(2'b11);
        cyc(1);
        check("R8 ofs_start", ofs_start, 1);
        ofs_done = 1'b1;
        cyc(1);
        ofs_done = 1'b0;
        check("R8 offset bit after done", cfg_rdata[1], 0);
        // R9 both pending: tune first, offset after
        wr(2'b10);
        check("R9 offset pending", cfg_rdata[1], 1);
        cyc(1);
        check("R9 tune goes first", tune_start, 1);
        check("R9 offset waits", ofs_start, 0);
        while (cfg_rdata[2]) cyc(1);
        check("R9 idle cycle between", ofs_start, 0);
        cyc(1);
        check("R9 offset after tune", ofs_start, 1);
        while (cfg_rdata[1]) cyc(1);
        // R9 periodic run deferred by an offset correction
        while (!tune_start) cyc(1);
        while (cfg_rdata[2]) cyc(1);
        cyc(P - 4);
        wr(2'b10);
        cyc(1);
        check("R9 offset straddles due point", ofs_start, 1);
        while (cfg_rdata[1]) cyc(1);
        check("R9 idle after offset", cfg_rdata[2], 0);
        cyc(1);
        check("R9 deferred periodic run", tune_start, 1);
        // Random phase, checked against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            tune_done = ($urandom_range(0, 7) == 0);
            ofs_done  = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 15) == 0) begin
                cfg_we = 1'b1;
                cfg_wdata = 2'($urandom_range(0, 3));
            end else begin
                cfg_we = 1'b0;
            end
            cyc(1);
        end
        cfg_we = 1'b0;
        tune_done = 1'b0;
        ofs_done = 1'b0;
        cyc(2);
        finish_run();
    end
endmodule